// File: doc/BRIEF.md
# I2C Controller Interrupt and Abort Status Unit

This unit holds the interrupt state of a FIFO-based I2C master. It merges two kinds of source into one 12-bit raw status word. Level sources follow the FIFO fill levels against programmed thresholds and clear themselves. Sticky sources capture single-cycle event pulses (FIFO overflow and underflow, transmit abort, START and STOP detection, bus activity, general call) and hold them until software reads a clear register. The register decode outside the unit turns those reads into one-cycle clear strobes: one strobe for each sticky source, plus a global clear.

A 12-bit mask selects which raw bits reach the masked status word. The OR of the masked bits drives one interrupt line. A transmit abort also records its cause bits in an accumulating cause register and holds the TX FIFO in flush until the abort is cleared. A clear of the activity bit is refused while the bus is still busy.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset all sticky raw bits and the abort cause are 0. Raw bit positions are: general call 11, START detect 10, STOP detect 9, activity 8, TX abort 6, TX empty 4, TX overflow 3, RX full 2, RX overflow 1, RX underflow 0. Bits 5 and 7 always read 0.
- R2: Raw bit 4 (TX empty) is 1 in the same cycle whenever `tx_level` is less than or equal to the effective TX threshold, and 0 otherwise.
- R3: Raw bit 2 (RX full) is 1 in the same cycle whenever `rx_level` is greater than or equal to the effective RX threshold, and 0 otherwise.
- R4: A threshold value from 0 to FIFO_DEPTH-1 is used as written. Any larger value is used as FIFO_DEPTH-1, which is 15 by default.
- R5: An event pulse sets its sticky raw bit from the next clock edge. The bit stays set until it is cleared.
- R6: A per-source clear strobe clears only its own sticky bit at the next edge.
- R7: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `abort_req` sets raw bit 6 and ORs `abort_cause_in` into `abort_cause`. `tx_flush` is high exactly while bit 6 is set. `rd_clr_tx_abort` clears bit 6, `tx_flush` and `abort_cause` together.
- R9: `rd_clr_all` clears every sticky bit and `abort_cause`. It leaves raw bits 4 and 2 unchanged.
- R10: While `bus_busy` is high, neither `rd_clr_activity` nor `rd_clr_all` clears raw bit 8.
- R11: `irq_mask` resets to 0x8FF. `mask_we` loads `mask_wdata` at the next edge. `irq_stat` equals `raw_stat` AND `irq_mask`.
- R12: `irq_line` is 1 exactly when any bit of `irq_stat` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_gen_call | input | 1 | General call received pulse |
| ev_start_det | input | 1 | START or repeated START seen pulse |
| ev_stop_det | input | 1 | STOP seen pulse |
| ev_activity | input | 1 | Bus activity pulse |
| ev_tx_over | input | 1 | Write to a full TX FIFO pulse |
| ev_rx_over | input | 1 | Received data lost pulse |
| ev_rx_under | input | 1 | Read from an empty RX FIFO pulse |
| abort_req | input | 1 | Transmit abort pulse |
| abort_cause_in | input | CAUSE_W | Cause bits that come with `abort_req` |
| bus_busy | input | 1 | Bus still active |
| tx_level | input | LVL_W | TX FIFO fill level |
| rx_level | input | LVL_W | RX FIFO fill level |
| tx_thresh | input | TH_W | Programmed TX threshold |
| rx_thresh | input | TH_W | Programmed RX threshold |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 12 | New mask value |
| rd_clr_all | input | 1 | Global clear read strobe |
| rd_clr_gen_call | input | 1 | General call clear strobe |
| rd_clr_start_det | input | 1 | START detect clear strobe |
| rd_clr_stop_det | input | 1 | STOP detect clear strobe |
| rd_clr_activity | input | 1 | Activity clear strobe |
| rd_clr_tx_abort | input | 1 | Abort clear strobe |
| rd_clr_tx_over | input | 1 | TX overflow clear strobe |
| rd_clr_rx_over | input | 1 | RX overflow clear strobe |
| rd_clr_rx_under | input | 1 | RX underflow clear strobe |
| raw_stat | output | 12 | Raw status word |
| irq_stat | output | 12 | Masked status word |
| irq_mask | output | 12 | Current mask |
| irq_line | output | 1 | Combined interrupt |
| tx_flush | output | 1 | Hold the TX FIFO flushed |
| abort_cause | output | CAUSE_W | Accumulated abort cause |

## Verification
Raw bits 4 and 2, the masked word and the interrupt line are combinational from the levels and thresholds, so they are due in the same cycle as their inputs. Sticky bits, the abort cause, `tx_flush` and the mask change one rising edge after their event, clear or write strobe. The bench drives every input on the falling edge and compares all outputs 2 ns later against a bench model. It updates that model only at the following rising edge, so each check sees the state left by the previous edge combined with the current levels. Directed sequences cover clamped thresholds, set against clear in one cycle, activity clears while the bus is busy, abort cause accumulation and the global clear. Seeded random traffic covers the rest.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int STAT_W = 12;

    // raw status bit positions (decoded by software)
    localparam int POS_RX_UNDER  = 0;
    localparam int POS_RX_OVER   = 1;
    localparam int POS_RX_FULL   = 2;
    localparam int POS_TX_OVER   = 3;
    localparam int POS_TX_EMPTY  = 4;
    localparam int POS_TX_ABRT   = 6;
    localparam int POS_ACTIVITY  = 8;
    localparam int POS_STOP_DET  = 9;
    localparam int POS_START_DET = 10;
    localparam int POS_GEN_CALL  = 11;

    // sticky source slots
    localparam int NUM_STICKY = 8;
    localparam int S_GEN_CALL  = 0;
    localparam int S_START_DET = 1;
    localparam int S_STOP_DET  = 2;
    localparam int S_ACTIVITY  = 3;
    localparam int S_TX_ABRT   = 4;
    localparam int S_TX_OVER   = 5;
    localparam int S_RX_OVER   = 6;
    localparam int S_RX_UNDER  = 7;

    localparam int STICKY_POS [NUM_STICKY] = '{
        POS_GEN_CALL, POS_START_DET, POS_STOP_DET, POS_ACTIVITY,
        POS_TX_ABRT, POS_TX_OVER, POS_RX_OVER, POS_RX_UNDER
    };

    localparam logic [STAT_W-1:0] MASK_RESET = 12'h8FF;

    typedef logic [STAT_W-1:0] stat_t;

endpackage

// File: rtl/i2c_irq_level.sv
module i2c_irq_level #(
    parameter int DEPTH       = 16,
    parameter int LVL_W       = 5,
    parameter int TH_W        = 8,
    parameter bit AT_OR_ABOVE = 1'b0
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [TH_W-1:0]  thresh_i,
    output logic             hit_o
);
    localparam logic [TH_W-1:0] TH_MAX = TH_W'(DEPTH - 1);

    logic [TH_W-1:0] th_eff;
    logic [TH_W-1:0] lvl_ext;

    always_comb begin
        th_eff  = (thresh_i > TH_MAX) ? TH_MAX : thresh_i;
        lvl_ext = TH_W'(level_i);
    end

    generate
        if (AT_OR_ABOVE) begin : g_ge
            assign hit_o = (lvl_ext >= th_eff);
        end else begin : g_le
            assign hit_o = (lvl_ext <= th_eff);
        end
    endgenerate

endmodule

// File: rtl/i2c_irq_sticky_bit.sv
module i2c_irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic bit_o
);
    typedef struct packed {
        logic flag;
    } sticky_state_t;

    sticky_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.flag;

    // R5 R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> bit_o);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !bit_o);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(bit_o));

endmodule

// File: rtl/i2c_irq_abort_track.sv
module i2c_irq_abort_track #(
    parameter int CAUSE_W = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               clr_i,
    output logic [CAUSE_W-1:0] cause_o
);
    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
    } abort_state_t;

    abort_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cause = '0;
        end
        if (abort_i) begin
            st_d.cause = st_d.cause | cause_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;

    // R8
    cause_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> ((cause_o & $past(cause_i)) == $past(cause_i)));

    // R8 R9
    cause_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !abort_i) |=> (cause_o == '0));

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TH_W       = 8,
    parameter int CAUSE_W    = 17,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_gen_call,
    input  logic               ev_start_det,
    input  logic               ev_stop_det,
    input  logic               ev_activity,
    input  logic               ev_tx_over,
    input  logic               ev_rx_over,
    input  logic               ev_rx_under,
    input  logic               abort_req,
    input  logic [CAUSE_W-1:0] abort_cause_in,
    input  logic               bus_busy,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [TH_W-1:0]    tx_thresh,
    input  logic [TH_W-1:0]    rx_thresh,
    input  logic               mask_we,
    input  logic [STAT_W-1:0]  mask_wdata,
    input  logic               rd_clr_all,
    input  logic               rd_clr_gen_call,
    input  logic               rd_clr_start_det,
    input  logic               rd_clr_stop_det,
    input  logic               rd_clr_activity,
    input  logic               rd_clr_tx_abort,
    input  logic               rd_clr_tx_over,
    input  logic               rd_clr_rx_over,
    input  logic               rd_clr_rx_under,
    output logic [STAT_W-1:0]  raw_stat,
    output logic [STAT_W-1:0]  irq_stat,
    output logic [STAT_W-1:0]  irq_mask,
    output logic               irq_line,
    output logic               tx_flush,
    output logic [CAUSE_W-1:0] abort_cause
);
    typedef struct packed {
        stat_t mask;
    } mask_state_t;

    logic [NUM_STICKY-1:0] ev_s;
    logic [NUM_STICKY-1:0] clr_s;
    logic [NUM_STICKY-1:0] flag_s;
    logic                  tx_empty;
    logic                  rx_full;
    mask_state_t           st_d, st_q;

    // event and clear routing into sticky slots
    always_comb begin
        ev_s              = '0;
        ev_s[S_GEN_CALL]  = ev_gen_call;
        ev_s[S_START_DET] = ev_start_det;
        ev_s[S_STOP_DET]  = ev_stop_det;
        ev_s[S_ACTIVITY]  = ev_activity;
        ev_s[S_TX_ABRT]   = abort_req;
        ev_s[S_TX_OVER]   = ev_tx_over;
        ev_s[S_RX_OVER]   = ev_rx_over;
        ev_s[S_RX_UNDER]  = ev_rx_under;

        clr_s              = '0;
        clr_s[S_GEN_CALL]  = rd_clr_all | rd_clr_gen_call;
        clr_s[S_START_DET] = rd_clr_all | rd_clr_start_det;
        clr_s[S_STOP_DET]  = rd_clr_all | rd_clr_stop_det;
        clr_s[S_ACTIVITY]  = (rd_clr_all | rd_clr_activity) & ~bus_busy;
        clr_s[S_TX_ABRT]   = rd_clr_all | rd_clr_tx_abort;
        clr_s[S_TX_OVER]   = rd_clr_all | rd_clr_tx_over;
        clr_s[S_RX_OVER]   = rd_clr_all | rd_clr_rx_over;
        clr_s[S_RX_UNDER]  = rd_clr_all | rd_clr_rx_under;
    end

    generate
        for (genvar k = 0; k < NUM_STICKY; k++) begin : g_sticky
            i2c_irq_sticky_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (ev_s[k]),
                .clr_i (clr_s[k]),
                .bit_o (flag_s[k])
            );
        end
    endgenerate

    i2c_irq_level #(
        .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .TH_W(TH_W), .AT_OR_ABOVE(1'b0)
    ) u_tx_level (
        .level_i  (tx_level),
        .thresh_i (tx_thresh),
        .hit_o    (tx_empty)
    );

    i2c_irq_level #(
        .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .TH_W(TH_W), .AT_OR_ABOVE(1'b1)
    ) u_rx_level (
        .level_i  (rx_level),
        .thresh_i (rx_thresh),
        .hit_o    (rx_full)
    );

    i2c_irq_abort_track #(
        .CAUSE_W(CAUSE_W)
    ) u_abort (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_i (abort_req),
        .cause_i (abort_cause_in),
        .clr_i   (clr_s[S_TX_ABRT]),
        .cause_o (abort_cause)
    );

    // mask register, two-process
    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= MASK_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // status word assembly
    always_comb begin
        raw_stat = '0;
        for (int k = 0; k < NUM_STICKY; k++) begin
            raw_stat[STICKY_POS[k]] = flag_s[k];
        end
        raw_stat[POS_TX_EMPTY] = tx_empty;
        raw_stat[POS_RX_FULL]  = rx_full;
    end

    assign irq_mask = st_q.mask;
    assign irq_stat = raw_stat & st_q.mask;
    assign irq_line = |irq_stat;
    assign tx_flush = flag_s[S_TX_ABRT];

    // R10
    activity_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && (rd_clr_activity || rd_clr_all) && raw_stat[POS_ACTIVITY])
        |=> raw_stat[POS_ACTIVITY]);

    // R11
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (irq_mask == $past(mask_wdata)));

    // R8
    flush_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_tx_abort && !abort_req) |=> !tx_flush);

    // R1
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[5] == 1'b0) && (raw_stat[7] == 1'b0));

endmodule

// File: tb/i2c_irq_status_test.sv
module i2c_irq_status_test;

    localparam int CAUSE_W = 17;
    localparam int LVL_W   = 5;
    localparam int TH_W    = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ev_gen_call, ev_start_det, ev_stop_det, ev_activity;
    logic               ev_tx_over, ev_rx_over, ev_rx_under, abort_req;
    logic [CAUSE_W-1:0] abort_cause_in;
    logic               bus_busy;
    logic [LVL_W-1:0]   tx_level, rx_level;
    logic [TH_W-1:0]    tx_thresh, rx_thresh;
    logic               mask_we;
    logic [11:0]        mask_wdata;
    logic               rd_clr_all, rd_clr_gen_call, rd_clr_start_det, rd_clr_stop_det;
    logic               rd_clr_activity, rd_clr_tx_abort, rd_clr_tx_over;
    logic               rd_clr_rx_over, rd_clr_rx_under;
    logic [11:0]        raw_stat, irq_stat, irq_mask;
    logic               irq_line, tx_flush;
    logic [CAUSE_W-1:0] abort_cause;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [11:0]        m_st;
    logic [CAUSE_W-1:0] m_cause;
    logic [11:0]        m_mask;

    always #10 clk = ~clk;

    i2c_irq_status uut (.*);

    function automatic logic [7:0] eff_th(input logic [7:0] t);
        return (t > 8'd15) ? 8'd15 : t;
    endfunction

    function automatic logic [11:0] exp_raw();
        logic [11:0] r;
        r    = m_st;
        r[4] = ({3'b000, tx_level} <= eff_th(tx_thresh));
        r[2] = ({3'b000, rx_level} >= eff_th(rx_thresh));
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        {ev_gen_call, ev_start_det, ev_stop_det, ev_activity} = '0;
        {ev_tx_over, ev_rx_over, ev_rx_under, abort_req} = '0;
        abort_cause_in = '0;
        mask_we = 1'b0;
        mask_wdata = '0;
        {rd_clr_all, rd_clr_gen_call, rd_clr_start_det, rd_clr_stop_det} = '0;
        {rd_clr_activity, rd_clr_tx_abort, rd_clr_tx_over} = '0;
        {rd_clr_rx_over, rd_clr_rx_under} = '0;
    endtask

    // compare outputs before the edge, then advance the model at the edge
    task automatic step();
        logic [11:0] ev, clr, er;
        #2;
        er = exp_raw();
        check("R1 R2 R3 R4 R5 R6 R7 R9 R10", "raw_stat", 32'(raw_stat), 32'(er));
        check("R11", "irq_stat", 32'(irq_stat), 32'(er & m_mask));
        check("R11", "irq_mask", 32'(irq_mask), 32'(m_mask));
        check("R12", "irq_line", 32'(irq_line), 32'(|(er & m_mask)));
        check("R8", "tx_flush", 32'(tx_flush), 32'(m_st[6]));
        check("R8 R9", "abort_cause", 32'(abort_cause), 32'(m_cause));
        @(posedge clk);
        ev = '0;
        ev[11] = ev_gen_call; ev[10] = ev_start_det; ev[9] = ev_stop_det;
        ev[8] = ev_activity;  ev[6] = abort_req;     ev[3] = ev_tx_over;
        ev[1] = ev_rx_over;   ev[0] = ev_rx_under;
        clr = '0;
        clr[11] = rd_clr_all | rd_clr_gen_call;
        clr[10] = rd_clr_all | rd_clr_start_det;
        clr[9]  = rd_clr_all | rd_clr_stop_det;
        clr[8]  = (rd_clr_all | rd_clr_activity) & ~bus_busy;
        clr[6]  = rd_clr_all | rd_clr_tx_abort;
        clr[3]  = rd_clr_all | rd_clr_tx_over;
        clr[1]  = rd_clr_all | rd_clr_rx_over;
        clr[0]  = rd_clr_all | rd_clr_rx_under;
        if (clr[6]) m_cause = '0;
        if (abort_req) m_cause = m_cause | abort_cause_in;
        m_st = (m_st & ~clr) | ev;
        if (mask_we) m_mask = mask_wdata;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        bus_busy = 1'b0;
        tx_level = '0; rx_level = '0; tx_thresh = '0; rx_thresh = 8'd4;
        m_st = '0; m_cause = '0; m_mask = 12'h8FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R11: reset state (TX empty with level 0, threshold 0)
        step();

        // R4: thresholds above 15 behave as 15
        tx_thresh = 8'd200; tx_level = 5'd15; rx_thresh = 8'd99; rx_level = 5'd15;
        step();
        tx_level = 5'd16; rx_level = 5'd14;
        step();
        tx_thresh = 8'd15; rx_thresh = 8'd16; rx_level = 5'd15;
        step();

        // R5 then R7: overflow set, then set and clear together
        ev_tx_over = 1'b1; step();
        rd_clr_tx_over = 1'b1; ev_tx_over = 1'b1; step();
        step();
        rd_clr_tx_over = 1'b1; step();
        step();

        // R10: activity clear refused while busy
        ev_activity = 1'b1; step();
        bus_busy = 1'b1; rd_clr_activity = 1'b1; step();
        rd_clr_all = 1'b1; step();
        step();
        bus_busy = 1'b0; rd_clr_activity = 1'b1; step();
        step();

        // R8: abort causes accumulate, flush holds, clear releases
        abort_req = 1'b1; abort_cause_in = 17'h00001; step();
        abort_req = 1'b1; abort_cause_in = 17'h10000; step();
        step();
        rd_clr_tx_abort = 1'b1; step();
        step();

        // R9 R6: several sources, one specific clear, then global clear
        ev_gen_call = 1'b1; ev_start_det = 1'b1; ev_stop_det = 1'b1;
        ev_rx_over = 1'b1; ev_rx_under = 1'b1; abort_req = 1'b1;
        abort_cause_in = 17'h00400; step();
        rd_clr_stop_det = 1'b1; step();
        mask_we = 1'b1; mask_wdata = 12'hFFF; step();
        rd_clr_all = 1'b1; step();
        step();

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            ev_gen_call  = ($urandom % 8) == 0;
            ev_start_det = ($urandom % 8) == 0;
            ev_stop_det  = ($urandom % 8) == 0;
            ev_activity  = ($urandom % 6) == 0;
            ev_tx_over   = ($urandom % 10) == 0;
            ev_rx_over   = ($urandom % 10) == 0;
            ev_rx_under  = ($urandom % 10) == 0;
            abort_req    = ($urandom % 12) == 0;
            abort_cause_in = CAUSE_W'($urandom);
            bus_busy     = ($urandom % 3) == 0;
            tx_level     = LVL_W'($urandom % 17);
            rx_level     = LVL_W'($urandom % 17);
            if (($urandom % 16) == 0) tx_thresh = TH_W'($urandom);
            if (($urandom % 16) == 0) rx_thresh = TH_W'($urandom % 20);
            mask_we      = ($urandom % 30) == 0;
            mask_wdata   = 12'($urandom);
            rd_clr_all       = ($urandom % 40) == 0;
            rd_clr_gen_call  = ($urandom % 9) == 0;
            rd_clr_start_det = ($urandom % 9) == 0;
            rd_clr_stop_det  = ($urandom % 9) == 0;
            rd_clr_activity  = ($urandom % 7) == 0;
            rd_clr_tx_abort  = ($urandom % 9) == 0;
            rd_clr_tx_over   = ($urandom % 9) == 0;
            rd_clr_rx_over   = ($urandom % 9) == 0;
            rd_clr_rx_under  = ($urandom % 9) == 0;
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule